// File: doc/BRIEF.md
# Serial DAC Input and Update Controller

This block is the digital front end of a serial-loaded 16-bit digital-to-analog converter. It watches five asynchronous pins: an active-low select, a serial clock, serial data, an active-low load strobe and an active-low clear. A fast system clock samples all five. Each pin passes through a two-flop synchroniser, and edges are detected on the synchronised copies. Data bits are shifted into a shift register, most significant bit first. A frame that closes with exactly 16 bits and no load-strobe fall is accepted. The accepted word is then moved into the converter code register.

The level of the load strobe selects the update mode. With the strobe held low, an accepted word reaches the code register when select rises. With the strobe held high, the word is kept in an input register as pending. It moves to the code register on the next strobe fall while select is high. The clear pin overrides everything else: it forces the reset code and cancels any pending word. A parameter picks the reset code, midscale (16'h8000) or zero.

The code output is a held level, and `update_pulse` marks each write like a valid strobe. There is no ready signal because the converter accepts every code, so the block applies no back-pressure. The serial clock must be oversampled at least four times, with each level held for at least two system clocks.

Top module: `sdac_front`

## Requirements
- R1: While `sel_n` is low, each rising edge of `ser_clk` shifts `ser_data` in, most significant bit first. With `load_n` low, a frame of exactly 16 bits closed by `sel_n` rising writes that word to `dac_code`.
- R2: The bit count carries on across any pause inside one select-low window, so two 8-bit bytes with a gap between them form one valid frame.
- R3: A frame with fewer than 16 bits (including none) or more than 16 bits is rejected. `dac_code` and any pending word stay unchanged, and `frame_err` pulses high for one cycle.
- R4: With `load_n` high, an accepted frame leaves `dac_code` unchanged and holds the word pending. A later falling edge of `load_n` while `sel_n` is high copies the pending word to `dac_code`.
- R5: A falling edge of `load_n` while `sel_n` is low corrupts the frame. The frame is rejected at `sel_n` rising, and `frame_err` pulses.
- R6: While `clear_n` is low, `dac_code` is held at the reset code, any pending word is cancelled, and no load takes effect.
- R7: After `rst_n`, `dac_code` equals the reset code: 16'h8000 when MIDSCALE=1 (the default), 16'h0000 otherwise. `update_pulse` and `frame_err` are low.
- R8: `update_pulse` is high for exactly one cycle for each write of the code register. A write is an immediate load, a deferred load, or the falling edge of `clear_n`. A `load_n` fall with nothing pending causes neither a write nor a pulse.
- R9: A pin edge that causes a write changes `dac_code` on the third rising system-clock edge after the pin changes: two synchroniser stages plus the code register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select pin |
| ser_clk | input | 1 | Serial bit clock pin; data is taken on its rising edge |
| ser_data | input | 1 | Serial data pin |
| load_n | input | 1 | Active-low load strobe pin; its level selects the update mode |
| clear_n | input | 1 | Active-low clear pin |
| dac_code | output | 16 | Converter code register |
| update_pulse | output | 1 | One-cycle marker for each code register write |
| frame_err | output | 1 | One-cycle pulse when a closed frame is rejected |

## Verification
The hardest state to reach from the ports is a deferred word that is pending while a second, defective frame passes through. The pending word must then survive and load on the later strobe fall. The stimulus builds this state directly. It loads a full word with `load_n` high, sends a short frame, and only then lowers `load_n`. It does the same with a pending word that is wiped by `clear_n`. A further case lowers `load_n` in the middle of a frame, between bytes. The exact output latency is checked by sampling the code on consecutive negative edges after `sel_n` rises.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int PIN_N = 5;

  typedef struct packed {
    logic clear_n;
    logic load_n;
    logic sel_n;
    logic ser_clk;
    logic ser_data;
  } pins_t;

  // idle levels of the pins, used as synchroniser reset values
  localparam pins_t PINS_IDLE = '{clear_n: 1'b1, load_n: 1'b0, sel_n: 1'b1,
                                  ser_clk: 1'b0, ser_data: 1'b0};
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int          W    = 5,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE[i];
        stab_q <= IDLE[i];
      end else begin
        meta_q <= raw[i];
        stab_q <= meta_q;
      end
    end
    assign synced[i] = stab_q;
  end
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel_fall,
  input  logic          sel_rise,
  input  logic          bit_strobe,
  input  logic          ser_data,
  input  logic          load_fall,
  output logic          frame_ok,
  output logic [DW-1:0] frame_word,
  output logic          frame_err
);
  localparam int          CW   = $clog2(DW + 2);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] OVER = CW'(DW + 1);

  logic [DW-1:0] shift_q;
  logic [CW-1:0] cnt_q;
  logic          bad_q;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
    end else if (sel_fall) begin
      cnt_q <= '0;
      bad_q <= load_fall;
    end else if (!sel_n) begin
      if (bit_strobe) begin
        shift_q <= {shift_q[DW-2:0], ser_data};
        if (cnt_q != OVER) cnt_q <= cnt_q + CW'(1);
      end
      if (load_fall) bad_q <= 1'b1;
    end
  end

  assign frame_ok   = sel_rise && (cnt_q == FULL) && !bad_q;
  assign frame_word = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= sel_rise && !frame_ok;
  end
  assign frame_err = err_q;

  // R1 / R2: every bit inside the window advances the count, pauses included
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !sel_fall && bit_strobe && cnt_q != OVER) |=> cnt_q == $past(cnt_q) + CW'(1));

  // R5: a strobe fall inside the window marks the frame bad
  a_r5_mark_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && load_fall) |=> bad_q);

  // R3: the count never passes the saturation value
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= OVER);
endmodule

// File: rtl/sdac_update_ctrl.sv
module sdac_update_ctrl #(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_ok,
  input  logic [DW-1:0] frame_word,
  input  logic          load_n,
  input  logic          load_fall,
  input  logic          sel_n,
  input  logic          clear_n,
  input  logic          clear_fall,
  output logic [DW-1:0] dac_code,
  output logic          update_pulse
);
  logic [DW-1:0] code_q, hold_q;
  logic          pend_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= RST_CODE;
      hold_q  <= RST_CODE;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (!clear_n) begin
        code_q  <= RST_CODE;
        pend_q  <= 1'b0;
        pulse_q <= clear_fall;
      end else if (frame_ok) begin
        hold_q <= frame_word;
        if (!load_n) begin
          code_q  <= frame_word;
          pend_q  <= 1'b0;
          pulse_q <= 1'b1;
        end else begin
          pend_q <= 1'b1;
        end
      end else if (load_fall && sel_n && pend_q) begin
        code_q  <= hold_q;
        pend_q  <= 1'b0;
        pulse_q <= 1'b1;
      end
    end
  end

  assign dac_code     = code_q;
  assign update_pulse = pulse_q;

  // R6: clear holds the reset code and drops any pending word
  a_r6_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (code_q == RST_CODE && !pend_q));

  // R4: an accepted frame with the strobe high leaves the code alone
  a_r4_defer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && load_n && clear_n) |=> (code_q == $past(code_q) && pend_q));

  // R8: every change of the code register comes with the pulse
  a_r8_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> pulse_q);
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int DW       = 16,
  parameter bit MIDSCALE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          load_n,
  input  logic          clear_n,
  output logic [DW-1:0] dac_code,
  output logic          update_pulse,
  output logic          frame_err
);
  import sdac_pkg::*;

  localparam logic [DW-1:0] RST_CODE = MIDSCALE ? (DW'(1) << (DW - 1)) : '0;

  pins_t raw_p, syn_p;
  logic  sel_d, clk_d, load_d, clear_d;
  logic  sel_fall, sel_rise, bit_strobe, load_fall, clear_fall;
  logic  frame_ok;
  logic [DW-1:0] frame_word;

  assign raw_p = '{clear_n: clear_n, load_n: load_n, sel_n: sel_n,
                   ser_clk: ser_clk, ser_data: ser_data};

  sdac_pin_sync #(.W(PIN_N), .IDLE(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw_p), .synced(syn_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d   <= PINS_IDLE.sel_n;
      clk_d   <= PINS_IDLE.ser_clk;
      load_d  <= PINS_IDLE.load_n;
      clear_d <= PINS_IDLE.clear_n;
    end else begin
      sel_d   <= syn_p.sel_n;
      clk_d   <= syn_p.ser_clk;
      load_d  <= syn_p.load_n;
      clear_d <= syn_p.clear_n;
    end
  end

  assign sel_fall   = sel_d && !syn_p.sel_n;
  assign sel_rise   = !sel_d && syn_p.sel_n;
  assign bit_strobe = !clk_d && syn_p.ser_clk;
  assign load_fall  = load_d && !syn_p.load_n;
  assign clear_fall = clear_d && !syn_p.clear_n;

  sdac_frame_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_n(syn_p.sel_n), .sel_fall(sel_fall),
    .sel_rise(sel_rise), .bit_strobe(bit_strobe), .ser_data(syn_p.ser_data),
    .load_fall(load_fall), .frame_ok(frame_ok), .frame_word(frame_word),
    .frame_err(frame_err)
  );

  sdac_update_ctrl #(.DW(DW), .RST_CODE(RST_CODE)) u_upd (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_word(frame_word),
    .load_n(syn_p.load_n), .load_fall(load_fall), .sel_n(syn_p.sel_n),
    .clear_n(syn_p.clear_n), .clear_fall(clear_fall),
    .dac_code(dac_code), .update_pulse(update_pulse)
  );

  // R7: reset code is present in the first cycle after reset
  a_r7_reset_code: assert property (@(posedge clk)
    $rose(rst_n) |-> dac_code == RST_CODE);
endmodule

// File: tb/sdac_front_bench.sv
module sdac_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, load_n = 1'b0, clear_n = 1'b1;
  logic [15:0] dac_code;
  logic update_pulse, frame_err;
  int nvec = 0, nbad = 0, npulse = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdac_front u_sdac_front (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code),
    .update_pulse(update_pulse), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    if (update_pulse) npulse++;
    if (frame_err) nerr++;
  end

  // {load high, bit count, word, expected code after the step}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 5'd16, 16'h1234, 16'h1234},
    {1'b0, 5'd16, 16'hFFFF, 16'hFFFF},
    {1'b1, 5'd16, 16'h0F0F, 16'h0F0F},
    {1'b0, 5'd8,  16'hAAAA, 16'h0F0F},
    {1'b0, 5'd17, 16'h5555, 16'h0F0F},
    {1'b0, 5'd16, 16'h7FFF, 16'h7FFF},
    {1'b1, 5'd16, 16'h8001, 16'h8001},
    {1'b0, 5'd0,  16'h3333, 16'h8001}
  };

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      ser_clk = 1'b0;
      ser_data = (i < 16) ? w[15-i] : 1'b0;
      waitc(4);
      ser_clk = 1'b1;
      waitc(4);
    end
    ser_clk = 1'b0;
    waitc(4);
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    sel_n = 1'b0; waitc(4);
    send_bits(w, 0, n);
    sel_n = 1'b1; waitc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    int p0, e0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    check("R7 reset code", dac_code, 16'h8000);
    check("R7 pulse idle", {15'd0, update_pulse}, 16'd0);
    check("R7 err idle", {15'd0, frame_err}, 16'd0);
    waitc(4);

    // table walk: R1 immediate, R3 short/long/empty, R4 deferred
    foreach (VEC[k]) begin
      prev = dac_code; p0 = npulse; e0 = nerr;
      load_n = VEC[k][37]; waitc(6);
      frame(VEC[k][31:16], int'(VEC[k][36:32]));
      if (VEC[k][37]) begin
        check("R4 held until strobe", dac_code, prev);
        load_n = 1'b0; waitc(6);
      end
      check(VEC[k][36:32] == 5'd16 ? "R1/R4 code" : "R3 rejected", dac_code, VEC[k][15:0]);
      check("R8 pulse count", 16'(npulse - p0), VEC[k][36:32] == 5'd16 ? 16'd1 : 16'd0);
      check("R3 err count", 16'(nerr - e0), VEC[k][36:32] == 5'd16 ? 16'd0 : 16'd1);
    end

    // R9 latency: pin rise, then 2 edges old, 3rd edge new
    sel_n = 1'b0; waitc(4);
    send_bits(16'hC3A5, 0, 16);
    prev = dac_code;
    sel_n = 1'b1;
    waitc(2);
    check("R9 two edges", dac_code, prev);
    waitc(1);
    check("R9 third edge", dac_code, 16'hC3A5);
    waitc(4);

    // R2 byte pause within one window
    sel_n = 1'b0; waitc(4);
    send_bits(16'h9C4E, 0, 8);
    waitc(40);
    send_bits(16'h9C4E, 8, 8);
    sel_n = 1'b1; waitc(6);
    check("R2 two bytes", dac_code, 16'h9C4E);

    // R5 strobe falls mid-frame
    load_n = 1'b1; waitc(6);
    p0 = npulse; e0 = nerr;
    sel_n = 1'b0; waitc(4);
    send_bits(16'h6666, 0, 8);
    load_n = 1'b0; waitc(4);
    send_bits(16'h6666, 8, 8);
    sel_n = 1'b1; waitc(6);
    check("R5 rejected", dac_code, 16'h9C4E);
    check("R5 err", 16'(nerr - e0), 16'd1);
    check("R5 no pulse", 16'(npulse - p0), 16'd0);

    // R3 pending word survives a short frame
    load_n = 1'b1; waitc(6);
    frame(16'h1111, 16);
    frame(16'h2222, 8);
    load_n = 1'b0; waitc(6);
    check("R3 pending intact", dac_code, 16'h1111);

    // R8 strobe fall with nothing pending
    p0 = npulse;
    load_n = 1'b1; waitc(6);
    load_n = 1'b0; waitc(6);
    check("R8 no pending no pulse", 16'(npulse - p0), 16'd0);
    check("R8 code kept", dac_code, 16'h1111);

    // R6 clear cancels pending word
    load_n = 1'b1; waitc(6);
    frame(16'h4444, 16);
    p0 = npulse;
    clear_n = 1'b0; waitc(6);
    check("R6 clear code", dac_code, 16'h8000);
    check("R8 clear pulse", 16'(npulse - p0), 16'd1);
    clear_n = 1'b1; waitc(6);
    load_n = 1'b0; waitc(6);
    check("R6 pending cancelled", dac_code, 16'h8000);

    // R6 clear blocks a load while low
    frame(16'h0123, 16);
    clear_n = 1'b0; waitc(6);
    frame(16'h5555, 16);
    check("R6 load blocked", dac_code, 16'h8000);
    clear_n = 1'b1; waitc(6);
    check("R6 after release", dac_code, 16'h8000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule